// File: doc/BRIEF.md
# Byte-Coded 8-Bit Teaching Processor

This block is a small 8-bit processor core. It runs a byte-coded program held in a 256-byte memory that sits outside the core and is reached over a simple synchronous bus. The bus has an address output, a write-data output and a write strobe. Read data returns combinationally in the same cycle. The core has four general-purpose registers, an instruction pointer and a three-bit status register. Every instruction is an opcode byte followed by one byte per operand. An operand byte holds a register code, an immediate value or a memory address. No operands are packed together, so most instructions take three bytes.

The core fetches one byte per clock cycle. After the last operand byte it spends one execute cycle, in which it may also make a data read or a data write. The arithmetic covers increment, add, subtract, multiply, divide and modulo. Multiply, divide and modulo each return a single 8-bit result. Moves load or store a register using an immediate, a fixed address or a register used as a pointer. The core stops on a halt opcode. It also stops, and raises a fault output, on an unknown opcode or a zero divisor.

Top module: `bcpu_core`

## Requirements
- R1: A synchronous reset clears all four registers, the instruction pointer and the flags, and drops `halted` and `fault`. The first cycle after reset fetches from address 0x00.
- R2: Operand register codes are AL=0x00, BL=0x01, CL=0x02 and DL=0x03. Only the low two bits of a register-code byte are used.
- R3: Each instruction byte is read in its own cycle at consecutive addresses. A two-byte instruction takes 3 cycles, a three-byte instruction takes 4 cycles, and HALT takes 1. The instruction pointer advances by the instruction length and wraps from 0xFF to 0x00.
- R4: INC (0xA4, reg) adds one to the register. The overflow flag is set only when the register held 0x7F.
- R5: ADD and SUB exist as register,register (0xA0, 0xA1) and register,immediate (0xB0, 0xB1) forms. The result is written to the first register. Overflow is set on signed two's-complement overflow.
- R6: MUL (0xA2 register form, 0xB2 immediate form) keeps the low 8 bits of the unsigned product. Overflow is set when the full product exceeds 0xFF.
- R7: DIV (0xA3, 0xB3) gives the unsigned quotient and MOD (0xA6, 0xB6) gives the unsigned remainder. Both clear overflow.
- R8: DIV or MOD with a zero divisor writes no register, leaves the flags unchanged and makes no memory write. It raises `fault` and `halted` one cycle after its execute cycle.
- R9: Moves are the following. 0xD0 r,imm loads an immediate. 0xD1 r,[addr] loads from a fixed address. 0xD2 [addr],r stores to a fixed address. 0xD3 r,[r2] loads through a pointer register. 0xD4 [r1],r2 stores through a pointer register. A store pulses `mem_we` for exactly its execute cycle, and no move changes the flags.
- R10: HALT (0x00) sets `halted` after its fetch cycle. Any opcode not listed in these requirements sets both `halted` and `fault`. While halted, the core drives `mem_addr` to 0x00 with `mem_we` low and holds the flags until the next reset.
- R11: The flags output is {overflow, sign, zero} in bits 2, 1 and 0. Sign copies bit 7 of the result and zero marks a result of 0x00. The flags are updated only by the arithmetic instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address for fetch, load or store |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| mem_wdata | output | 8 | Store data, meaningful while `mem_we` is high |
| mem_we | output | 1 | Memory write strobe |
| flags | output | 3 | Status register {overflow, sign, zero} |
| halted | output | 1 | Execution stopped |
| fault | output | 1 | Stop caused by zero divisor or unknown opcode |

## Verification
Any corruption of the instruction pointer or the sequencing state shows on `mem_addr` in the very next cycle, because every cycle drives a predictable address. Comparing the bus on every clock therefore pins down a bad fetch length, a missed wrap or a wrong effective address at the cycle where it happens. A wrong register value stays hidden until it reaches a store, a pointer address or the flags, which can be several instructions later. The test programs therefore store every register they touch and load through pointer registers, so that a bad write-back surfaces within a few cycles. Zero-divisor, unknown-opcode and halt cases are checked by the exact cycle at which `halted` rises and by memory that must stay unwritten.

// File: rtl/bcpu_pkg.sv
`timescale 1ns/1ps
package bcpu_pkg;

    localparam int DW   = 8;
    localparam int AW   = 8;
    localparam int NREG = 4;
    localparam int RW   = $clog2(NREG);

    typedef logic [DW-1:0] word_t;
    typedef logic [AW-1:0] addr_t;
    typedef logic [RW-1:0] rsel_t;

    localparam word_t OP_HALT   = 8'h00;
    localparam word_t OP_ADD_RR = 8'hA0;
    localparam word_t OP_SUB_RR = 8'hA1;
    localparam word_t OP_MUL_RR = 8'hA2;
    localparam word_t OP_DIV_RR = 8'hA3;
    localparam word_t OP_INC    = 8'hA4;
    localparam word_t OP_MOD_RR = 8'hA6;
    localparam word_t OP_ADD_RI = 8'hB0;
    localparam word_t OP_SUB_RI = 8'hB1;
    localparam word_t OP_MUL_RI = 8'hB2;
    localparam word_t OP_DIV_RI = 8'hB3;
    localparam word_t OP_MOD_RI = 8'hB6;
    localparam word_t OP_MOV_RI = 8'hD0;
    localparam word_t OP_LD_DIR = 8'hD1;
    localparam word_t OP_ST_DIR = 8'hD2;
    localparam word_t OP_LD_PTR = 8'hD3;
    localparam word_t OP_ST_PTR = 8'hD4;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV, ALU_MOD
    } alu_op_e;

    typedef enum logic [2:0] {
        K_ALU, K_MOVI, K_LOAD, K_STORE, K_HALT, K_BAD
    } kind_e;

    typedef enum logic [2:0] {
        S_FETCH, S_OP1, S_OP2, S_EXEC, S_STOP
    } state_e;

    typedef struct packed {
        kind_e   kind;
        alu_op_e alu;
        logic    src_imm;
        logic    inc;
        logic    ptr;
        logic    two_ops;
    } decoded_t;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
    } flags_t;

    function automatic flags_t make_flags(word_t r, logic ovf);
        flags_t f;
        f.ovf  = ovf;
        f.sign = r[DW-1];
        f.zero = (r == '0);
        return f;
    endfunction

endpackage

// File: rtl/bcpu_decode.sv
`timescale 1ns/1ps
module bcpu_decode
    import bcpu_pkg::*;
(
    input  word_t    opcode,
    output decoded_t dec
);

    always_comb begin
        dec.kind    = K_BAD;
        dec.alu     = ALU_ADD;
        dec.src_imm = 1'b0;
        dec.inc     = 1'b0;
        dec.ptr     = 1'b0;
        dec.two_ops = 1'b1;
        case (opcode)
            OP_HALT: dec.kind = K_HALT;
            OP_INC: begin
                dec.kind    = K_ALU;
                dec.inc     = 1'b1;
                dec.two_ops = 1'b0;
            end
            OP_ADD_RR, OP_ADD_RI: begin
                dec.kind    = K_ALU;
                dec.alu     = ALU_ADD;
                dec.src_imm = opcode[4];
            end
            OP_SUB_RR, OP_SUB_RI: begin
                dec.kind    = K_ALU;
                dec.alu     = ALU_SUB;
                dec.src_imm = opcode[4];
            end
            OP_MUL_RR, OP_MUL_RI: begin
                dec.kind    = K_ALU;
                dec.alu     = ALU_MUL;
                dec.src_imm = opcode[4];
            end
            OP_DIV_RR, OP_DIV_RI: begin
                dec.kind    = K_ALU;
                dec.alu     = ALU_DIV;
                dec.src_imm = opcode[4];
            end
            OP_MOD_RR, OP_MOD_RI: begin
                dec.kind    = K_ALU;
                dec.alu     = ALU_MOD;
                dec.src_imm = opcode[4];
            end
            OP_MOV_RI: dec.kind = K_MOVI;
            OP_LD_DIR: dec.kind = K_LOAD;
            OP_LD_PTR: begin
                dec.kind = K_LOAD;
                dec.ptr  = 1'b1;
            end
            OP_ST_DIR: dec.kind = K_STORE;
            OP_ST_PTR: begin
                dec.kind = K_STORE;
                dec.ptr  = 1'b1;
            end
            default: dec.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/bcpu_alu.sv
`timescale 1ns/1ps
module bcpu_alu
    import bcpu_pkg::*;
(
    input  alu_op_e op,
    input  word_t   x,
    input  word_t   y,
    output word_t   res,
    output flags_t  fl,
    output logic    div_zero
);

    localparam int PW = 2 * DW;

    logic [PW-1:0] prod;
    logic          ovf;

    always_comb begin
        prod     = PW'(x) * PW'(y);
        res      = '0;
        ovf      = 1'b0;
        div_zero = ((op == ALU_DIV) || (op == ALU_MOD)) && (y == '0);
        case (op)
            ALU_ADD: begin
                res = x + y;
                ovf = (x[DW-1] == y[DW-1]) && (res[DW-1] != x[DW-1]);
            end
            ALU_SUB: begin
                res = x - y;
                ovf = (x[DW-1] != y[DW-1]) && (res[DW-1] != x[DW-1]);
            end
            ALU_MUL: begin
                res = prod[DW-1:0];
                ovf = |prod[PW-1:DW];
            end
            ALU_DIV: res = div_zero ? x : (x / y);
            ALU_MOD: res = div_zero ? x : (x % y);
            default: res = '0;
        endcase
        fl = make_flags(res, ovf);
    end

endmodule

// File: rtl/bcpu_regfile.sv
`timescale 1ns/1ps
module bcpu_regfile
    import bcpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  rsel_t wsel,
    input  word_t wdata,
    input  rsel_t rsel_a,
    input  rsel_t rsel_b,
    output word_t rdata_a,
    output word_t rdata_b
);

    word_t regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && (wsel == rsel_t'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[rsel_a];
    assign rdata_b = regs[rsel_b];

endmodule

// File: rtl/bcpu_core.sv
`timescale 1ns/1ps
module bcpu_core
    import bcpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic [2:0]    flags,
    output logic          halted,
    output logic          fault
);

    state_e   state;
    addr_t    ip;
    word_t    opc;
    word_t    opa;
    word_t    opb;
    flags_t   flags_q;
    logic     fault_q;

    word_t    dec_in;
    decoded_t dec;
    word_t    rf_a;
    word_t    rf_b;
    word_t    alu_y;
    word_t    alu_res;
    flags_t   alu_fl;
    logic     div_zero;
    logic     rf_we;
    word_t    rf_wdata;

    // During the fetch cycle the opcode is still on the bus; afterwards it is held.
    assign dec_in = (state == S_FETCH) ? mem_rdata : opc;

    bcpu_decode u_dec (
        .opcode (dec_in),
        .dec    (dec)
    );

    bcpu_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .wsel    (rsel_t'(opa)),
        .wdata   (rf_wdata),
        .rsel_a  (rsel_t'(opa)),
        .rsel_b  (rsel_t'(opb)),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    always_comb begin
        if (dec.inc) begin
            alu_y = word_t'(1);
        end else if (dec.src_imm) begin
            alu_y = opb;
        end else begin
            alu_y = rf_b;
        end
    end

    bcpu_alu u_alu (
        .op       (dec.alu),
        .x        (rf_a),
        .y        (alu_y),
        .res      (alu_res),
        .fl       (alu_fl),
        .div_zero (div_zero)
    );

    always_comb begin
        rf_we    = 1'b0;
        rf_wdata = alu_res;
        if (state == S_EXEC) begin
            case (dec.kind)
                K_ALU:  rf_we = !div_zero;
                K_MOVI: begin
                    rf_we    = 1'b1;
                    rf_wdata = opb;
                end
                K_LOAD: begin
                    rf_we    = 1'b1;
                    rf_wdata = mem_rdata;
                end
                default: rf_we = 1'b0;
            endcase
        end
    end

    always_comb begin
        mem_addr = ip;
        case (state)
            S_EXEC: begin
                if (dec.kind == K_LOAD) begin
                    mem_addr = dec.ptr ? addr_t'(rf_b) : addr_t'(opb);
                end else if (dec.kind == K_STORE) begin
                    mem_addr = dec.ptr ? addr_t'(rf_a) : addr_t'(opa);
                end
            end
            S_STOP:  mem_addr = '0;
            default: mem_addr = ip;
        endcase
    end

    assign mem_we    = (state == S_EXEC) && (dec.kind == K_STORE);
    assign mem_wdata = rf_b;
    assign flags     = flags_q;
    assign halted    = (state == S_STOP);
    assign fault     = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_FETCH;
            ip      <= '0;
            opc     <= '0;
            opa     <= '0;
            opb     <= '0;
            flags_q <= '0;
            fault_q <= 1'b0;
        end else begin
            case (state)
                S_FETCH: begin
                    opc <= mem_rdata;
                    ip  <= ip + AW'(1);
                    if (dec.kind == K_HALT) begin
                        state <= S_STOP;
                    end else if (dec.kind == K_BAD) begin
                        state   <= S_STOP;
                        fault_q <= 1'b1;
                    end else begin
                        state <= S_OP1;
                    end
                end
                S_OP1: begin
                    opa   <= mem_rdata;
                    ip    <= ip + AW'(1);
                    state <= dec.two_ops ? S_OP2 : S_EXEC;
                end
                S_OP2: begin
                    opb   <= mem_rdata;
                    ip    <= ip + AW'(1);
                    state <= S_EXEC;
                end
                S_EXEC: begin
                    if ((dec.kind == K_ALU) && div_zero) begin
                        state   <= S_STOP;
                        fault_q <= 1'b1;
                    end else begin
                        if (dec.kind == K_ALU) begin
                            flags_q <= alu_fl;
                        end
                        state <= S_FETCH;
                    end
                end
                default: state <= S_STOP;
            endcase
        end
    end

endmodule

// File: rtl/bcpu_core_chk.sv
`timescale 1ns/1ps
module bcpu_core_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] mem_addr,
    input logic       mem_we,
    input logic [2:0] flags,
    input logic       halted,
    input logic       fault
);

    a_r1_first_fetch_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_addr == 8'h00 && !halted && !fault && flags == 3'b000));

    a_r8_fault_means_halted: assert property (@(posedge clk) disable iff (rst)
        fault |-> halted);

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r10_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (mem_addr == 8'h00 && !mem_we));

    a_r10_flags_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(flags));

    a_r9_store_single_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r11_store_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(flags));

endmodule

bind bcpu_core bcpu_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .flags    (flags),
    .halted   (halted),
    .fault    (fault)
);

// File: tb/sim_bcpu_core.sv
`timescale 1ns/1ps
module sim_bcpu_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [2:0] flags;
    logic       halted;
    logic       fault;

    always #2 clk = ~clk;

    bcpu_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .flags     (flags),
        .halted    (halted),
        .fault     (fault)
    );

    // Bench-owned memory, with a loader port used while reset is held.
    logic [7:0] ram [256];
    logic       ld_en = 1'b0;
    logic [7:0] ld_a  = 8'h00;
    logic [7:0] ld_d  = 8'h00;

    assign mem_rdata = ram[mem_addr];

    always @(posedge clk) begin
        if (ld_en) ram[ld_a] <= ld_d;
        else if (mem_we) ram[mem_addr] <= mem_wdata;
    end

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    typedef struct {
        logic [7:0] a;
        logic       we;
        logic [7:0] wd;
        logic [2:0] fl;
        logic       h;
        logic       f;
        int         req;
    } exp_t;

    exp_t       q[$];
    logic [7:0] img  [256];
    logic [7:0] mref [256];
    logic [7:0] mr   [4];
    logic [7:0] mip;
    logic [2:0] mfl;
    bit         mh, mf;
    int         wp;
    int         halt_cycle;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic we, input logic [7:0] wd, input int req);
        exp_t e;
        e.a = a; e.we = we; e.wd = wd; e.fl = mfl; e.h = 1'b0; e.f = 1'b0; e.req = req;
        q.push_back(e);
    endtask

    // Behavioural model of one instruction: pushes the expected bus cycles.
    task automatic model_instr();
        logic [7:0] op, b1, b2, x, y, r, pa;
        int sx, sy, sr, p, req;
        logic ov;
        op = mref[mip];
        b1 = mref[mip + 8'd1];
        b2 = mref[mip + 8'd2];
        case (op)
            8'h00: begin
                push(mip, 1'b0, 8'h00, 10);  // R10 halt
                mh = 1'b1;
            end
            8'hA4: begin  // R4 increment
                push(mip, 1'b0, 8'h00, 4);
                push(mip + 8'd1, 1'b0, 8'h00, 4);
                push(mip + 8'd2, 1'b0, 8'h00, 4);
                x = mr[b1[1:0]];
                r = x + 8'd1;
                ov = (int'($signed(x)) + 1) > 127;
                mr[b1[1:0]] = r;
                mfl = {ov, r[7], (r == 8'h00)};
                mip = mip + 8'd2;
            end
            8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA6, 8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB6: begin
                case (op[3:0])
                    4'h0, 4'h1: req = 5;
                    4'h2:       req = 6;
                    default:    req = 7;
                endcase
                x = mr[b1[1:0]];
                y = op[4] ? b2 : mr[b2[1:0]];
                if ((op[3:0] == 4'h3 || op[3:0] == 4'h6) && y == 8'h00) req = 8;
                push(mip, 1'b0, 8'h00, req);
                push(mip + 8'd1, 1'b0, 8'h00, req);
                push(mip + 8'd2, 1'b0, 8'h00, req);
                push(mip + 8'd3, 1'b0, 8'h00, req);
                sx = int'($signed(x));
                sy = int'($signed(y));
                ov = 1'b0;
                r  = 8'h00;
                if (req == 8) begin
                    mh = 1'b1;
                    mf = 1'b1;
                end else begin
                    case (op[3:0])
                        4'h0: begin sr = sx + sy; r = 8'(sr); ov = (sr > 127) || (sr < -128); end
                        4'h1: begin sr = sx - sy; r = 8'(sr); ov = (sr > 127) || (sr < -128); end
                        4'h2: begin p = int'(x) * int'(y); r = 8'(p); ov = (p > 255); end
                        4'h3: r = x / y;
                        default: r = x % y;
                    endcase
                    mr[b1[1:0]] = r;
                    mfl = {ov, r[7], (r == 8'h00)};
                end
                mip = mip + 8'd3;
            end
            8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4: begin  // R9 moves
                push(mip, 1'b0, 8'h00, 9);
                push(mip + 8'd1, 1'b0, 8'h00, 9);
                push(mip + 8'd2, 1'b0, 8'h00, 9);
                case (op)
                    8'hD0: begin push(mip + 8'd3, 1'b0, 8'h00, 9); mr[b1[1:0]] = b2; end
                    8'hD1: begin push(b2, 1'b0, 8'h00, 9); mr[b1[1:0]] = mref[b2]; end
                    8'hD3: begin
                        pa = mr[b2[1:0]];
                        push(pa, 1'b0, 8'h00, 9);
                        mr[b1[1:0]] = mref[pa];
                    end
                    8'hD2: begin push(b1, 1'b1, mr[b2[1:0]], 9); mref[b1] = mr[b2[1:0]]; end
                    default: begin
                        pa = mr[b1[1:0]];
                        push(pa, 1'b1, mr[b2[1:0]], 9);
                        mref[pa] = mr[b2[1:0]];
                    end
                endcase
                mip = mip + 8'd3;
            end
            default: begin
                push(mip, 1'b0, 8'h00, 10);  // R10 unknown opcode
                mh = 1'b1;
                mf = 1'b1;
            end
        endcase
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'(i * 7 + 3);
        wp = 0;
    endtask

    task automatic e1(input logic [7:0] a);
        img[wp] = a;
        wp++;
    endtask

    task automatic e2(input logic [7:0] a, input logic [7:0] b);
        e1(a); e1(b);
    endtask

    task automatic e3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        e1(a); e1(b); e1(c);
    endtask

    task automatic run_prog(input string name);
        exp_t e;
        int n;
        int bad_ram;
        // load memory while reset is held
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            ld_en = 1'b1;
            ld_a  = 8'(i);
            ld_d  = img[i];
            mref[i] = img[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        // model from the reset state
        for (int i = 0; i < 4; i++) mr[i] = 8'h00;
        mip = 8'h00; mfl = 3'b000; mh = 1'b0; mf = 1'b0;
        q.delete();
        n = 0;
        while (!mh && n < 1000) begin
            model_instr();
            n++;
        end
        for (int i = 0; i < 3; i++) begin
            e.a = 8'h00; e.we = 1'b0; e.wd = 8'h00; e.fl = mfl;
            e.h = 1'b1; e.f = mf; e.req = mf ? 8 : 10;
            q.push_back(e);
        end
        q[0].req = 1;  // R1: first cycle after reset
        // release reset and compare on every cycle
        rst = 1'b0;
        #1;
        halt_cycle = -1;
        n = 0;
        while (q.size() > 0) begin
            e = q.pop_front();
            compared++;
            if (halted === 1'b1 && halt_cycle < 0) halt_cycle = n;
            if (mem_addr !== e.a || mem_we !== e.we || (e.we && mem_wdata !== e.wd) ||
                flags !== e.fl || halted !== e.h || fault !== e.f) begin
                mismatched++;
                $display("FAIL R%0d %s cycle %0d: got addr=%h we=%b wd=%h fl=%b h=%b f=%b expected addr=%h we=%b wd=%h fl=%b h=%b f=%b",
                         e.req, name, n, mem_addr, mem_we, mem_wdata, flags, halted, fault,
                         e.a, e.we, e.wd, e.fl, e.h, e.f);
            end
            n++;
            @(negedge clk);
            #1;
        end
        // whole-memory comparison against the model
        compared++;
        bad_ram = 0;
        for (int i = 0; i < 256; i++) begin
            if (ram[i] !== mref[i] && bad_ram == 0) begin
                bad_ram = 1;
                mismatched++;
                $display("FAIL R9 %s memory[%0h]: got %h expected %h", name, i, ram[i], mref[i]);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);

        // Program 1: INC, ADD, SUB, MUL with overflow; all registers stored (R2, R4, R5, R6)
        clear_img();
        e3(8'hD0, 8'h00, 8'h7F);
        e2(8'hA4, 8'h00);
        e3(8'hD0, 8'h01, 8'h80);
        e3(8'hA0, 8'h00, 8'h01);
        e3(8'hD0, 8'h02, 8'h05);
        e3(8'hB1, 8'h02, 8'h07);
        e3(8'hD0, 8'h03, 8'h20);
        e3(8'hB2, 8'h03, 8'h10);
        e3(8'hD2, 8'hF0, 8'h00);
        e3(8'hD2, 8'hF1, 8'h01);
        e3(8'hD2, 8'hF2, 8'h02);
        e3(8'hD2, 8'hF3, 8'h03);
        e1(8'h00);
        run_prog("arith");
        chk("R5 AL after 0x7F+1 then +0x80", ram[8'hF0], 8'h00);
        chk("R2 BL code 01 stored", ram[8'hF1], 8'h80);
        chk("R5 CL 5-7", ram[8'hF2], 8'hFE);
        chk("R6 DL 0x20*0x10 low byte", ram[8'hF3], 8'h00);
        chk("R6 flags after overflowing MUL", {5'b0, flags}, 8'h05);
        chk("R10 halted after HALT", {7'b0, halted}, 8'h01);
        chk("R10 no fault after HALT", {7'b0, fault}, 8'h00);

        // Program 2: DIV, MOD, MUL without overflow (R7, R6)
        clear_img();
        e3(8'hD0, 8'h00, 8'h64);
        e3(8'hD0, 8'h01, 8'h07);
        e3(8'hD0, 8'h02, 8'h64);
        e3(8'hA3, 8'h00, 8'h01);
        e3(8'hA6, 8'h02, 8'h01);
        e3(8'hB2, 8'h01, 8'h03);
        e3(8'hB6, 8'h00, 8'h04);
        e3(8'hD2, 8'hE0, 8'h00);
        e3(8'hD2, 8'hE1, 8'h01);
        e3(8'hD2, 8'hE2, 8'h02);
        e1(8'h00);
        run_prog("divmod");
        chk("R7 100/7 then mod 4", ram[8'hE0], 8'h02);
        chk("R6 7*3 no overflow", ram[8'hE1], 8'h15);
        chk("R7 100 mod 7", ram[8'hE2], 8'h02);
        chk("R7 flags after MOD", {5'b0, flags}, 8'h00);

        // Program 3: direct and pointer moves keep flags (R9, R11)
        clear_img();
        img[8'h80] = 8'h5A;
        img[8'h81] = 8'hC3;
        e3(8'hD0, 8'h00, 8'h03);
        e3(8'hB1, 8'h00, 8'h03);
        e3(8'hD1, 8'h00, 8'h80);
        e3(8'hD0, 8'h01, 8'h81);
        e3(8'hD3, 8'h02, 8'h01);
        e3(8'hD0, 8'h03, 8'hA0);
        e3(8'hD4, 8'h03, 8'h00);
        e3(8'hD2, 8'hA1, 8'h02);
        e1(8'h00);
        run_prog("moves");
        chk("R9 pointer store of direct load", ram[8'hA0], 8'h5A);
        chk("R9 direct store of pointer load", ram[8'hA1], 8'hC3);
        chk("R11 zero flag kept across moves", {5'b0, flags}, 8'h01);

        // Program 4: DIV by zero register (R8)
        clear_img();
        e3(8'hD0, 8'h00, 8'h09);
        e3(8'hD0, 8'h01, 8'h00);
        e3(8'hB0, 8'h00, 8'hF7);
        e3(8'hA3, 8'h00, 8'h01);
        e3(8'hD2, 8'hC0, 8'h00);
        e1(8'h00);
        run_prog("divzero");
        chk("R8 fault on zero divisor", {7'b0, fault}, 8'h01);
        chk("R8 no store after fault", ram[8'hC0], 8'(8'hC0 * 7 + 3));
        chk("R8 flags unchanged", {5'b0, flags}, 8'h01);
        chk("R8 halt cycle", 8'(halt_cycle), 8'd16);

        // Program 5: MOD by zero immediate (R8)
        clear_img();
        e3(8'hD0, 8'h02, 8'h11);
        e3(8'hB6, 8'h02, 8'h00);
        e1(8'h00);
        run_prog("modzero");
        chk("R8 fault on MOD by zero", {7'b0, fault}, 8'h01);

        // Program 6: unknown opcode (R10)
        clear_img();
        e3(8'hD0, 8'h00, 8'h01);
        e1(8'hFF);
        run_prog("badop");
        chk("R10 fault on unknown opcode", {7'b0, fault}, 8'h01);
        chk("R10 halt cycle after unknown opcode", 8'(halt_cycle), 8'd5);

        // Program 7: instruction pointer wraps past 0xFF (R3)
        clear_img();
        e3(8'hD0, 8'h00, 8'h05);
        e3(8'hD2, 8'h00, 8'h01);
        for (int i = 0; i < 125; i++) e2(8'hA4, 8'h02);
        run_prog("wrap");
        chk("R3 HALT written to 0x00 reached after wrap", ram[8'h00], 8'h00);
        chk("R3 cycles to halt across wrap", 8'((halt_cycle >> 8) & 255), 8'd1);
        chk("R3 cycles to halt low byte", 8'(halt_cycle & 255), 8'd128);
        chk("R4 flags after 125 increments", {5'b0, flags}, 8'h00);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule